// File: doc/BRIEF.md
# Pacing Loop Tachycardia Breaker

This block watches for a tachycardia that the pacing system sustains by itself. In such a loop every ventricular pace travels back to the atrium. The atrial sense that results starts a new atrioventricular delay, and the next ventricular pace follows at the upper-rate limit. The block times each pace-to-atrial-sense delay in milliseconds. The first delay of a run becomes the reference, and each later delay is compared with it. When enough delays in a row stay close to that reference, the loop is taken as confirmed.

On confirmation the block raises a sticky status. At the next ventricular pace it issues a single command to the external atrial refractory timer to lengthen its period, so that the following retrograde atrial sense falls inside the refractory period and does not start another atrioventricular delay. The block issues this command at most once between resets. The refractory timer and all other pacing timers lie outside the block.

Top module: `loop_breaker`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `loop_confirmed` and `arp_ext_cmd` are 0 and `arp_ext_ms` is 0.
- R2: An interval is the number of clock cycles with `tick_ms` high, counted from a `v_pace` taken while `at_upper` is high up to the next `a_sense`. An `a_sense` with no pace still waiting for its sense has no effect on the run.
- R3: The first interval of a run is stored as the reference of that run.
- R4: A later interval matches when its difference from the reference is at most TOL_MS (32) in either direction. A difference of exactly 32 matches.
- R5: `loop_confirmed` goes high after MATCH_N (16) matches in a row, which is the 17th interval of the run, and never earlier. It then stays high until reset.
- R6: An interval that does not match ends the run and discards the reference. The next interval becomes the new reference.
- R7: A cycle with `v_sense`, with `a_pace`, or with `at_upper` low ends the run and discards the reference.
- R8: After confirmation, the next `v_pace` makes `arp_ext_cmd` high for exactly one cycle, one clock after that pace. During that cycle `arp_ext_ms` equals EXT_MS (500); at all other times it is 0.
- R9: `arp_ext_cmd` pulses at most once between resets, whatever pacing follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle strobe per millisecond |
| v_pace | input | 1 | Ventricular pace delivered |
| v_sense | input | 1 | Ventricular sense |
| a_pace | input | 1 | Atrial pace delivered |
| a_sense | input | 1 | Atrial sense outside blanking |
| at_upper | input | 1 | Ventricular rate is at the upper-rate limit |
| loop_confirmed | output | 1 | Sticky: loop confirmed since reset |
| arp_ext_cmd | output | 1 | One-cycle command to lengthen atrial refractory |
| arp_ext_ms | output | EW (9) | Requested refractory length in ms, valid with the command |

## Verification
An interval counter that restarts late or early shifts every measured delay. A corrupt reference or match count shows up at `loop_confirmed`. The status then rises one interval too soon or too late, or it fails to rise after a run that is interrupted by a break. The scenarios therefore sample the status after the 16th and again after the 17th interval of each run. A broken lockout or a wrongly armed extension appears at `arp_ext_cmd` on the first ventricular pace after confirmation, and a second pulse can appear on any later pace.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int DEF_TOL_MS  = 32;
  localparam int DEF_MATCH_N = 16;
  localparam int DEF_MAX_MS  = 2000;
  localparam int DEF_EXT_MS  = 500;

  typedef enum logic [1:0] {
    DEC_IDLE,
    DEC_SEED,
    DEC_MATCH,
    DEC_BREAK
  } run_dec_e;
endpackage

// File: rtl/lb_span_timer.sv
module lb_span_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic          stop,
  input  logic          abort,
  output logic          cap_v,
  output logic [TW-1:0] cap_val
);
  localparam logic [TW-1:0] CNT_TOP = '1;

  logic          armed;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      cap_v   <= 1'b0;
      cap_val <= '0;
    end else begin
      cap_v <= 1'b0;
      if (abort) begin
        armed <= 1'b0;
      end else begin
        if (stop && armed) begin
          cap_v   <= 1'b1;
          cap_val <= cnt;
          armed   <= 1'b0;
        end
        if (start) begin
          armed <= 1'b1;
          cnt   <= '0;
        end else if (armed && tick && cnt != CNT_TOP) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lb_run_track.sv
module lb_run_track
  import lb_pkg::*;
#(
  parameter int TW      = 11,
  parameter int CW      = 5,
  parameter int TOL_MS  = 32,
  parameter int MATCH_N = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          hold,
  input  logic          cap_v,
  input  logic [TW-1:0] cap_val,
  output logic          hit
);
  localparam logic [CW-1:0] LAST_CNT = CW'(MATCH_N - 1);
  localparam logic [TW:0]   TOL_W    = (TW+1)'(TOL_MS);

  logic          ref_v;
  logic [TW-1:0] ref_val;
  logic [CW-1:0] cnt;
  logic [TW:0]   diff;
  run_dec_e      dec;

  always_comb begin
    if (cap_val >= ref_val) diff = {1'b0, cap_val} - {1'b0, ref_val};
    else                    diff = {1'b0, ref_val} - {1'b0, cap_val};
  end

  always_comb begin
    dec = DEC_IDLE;
    if (cap_v && !hold) begin
      if (!ref_v)              dec = DEC_SEED;
      else if (diff <= TOL_W)  dec = DEC_MATCH;
      else                     dec = DEC_BREAK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_v   <= 1'b0;
      ref_val <= '0;
      cnt     <= '0;
      hit     <= 1'b0;
    end else if (abort) begin
      ref_v <= 1'b0;
      cnt   <= '0;
      hit   <= 1'b0;
    end else begin
      hit <= 1'b0;
      unique case (dec)
        DEC_SEED: begin
          ref_v   <= 1'b1;
          ref_val <= cap_val;
          cnt     <= '0;
        end
        DEC_MATCH: begin
          if (cnt == LAST_CNT) begin
            hit   <= 1'b1;
            ref_v <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        DEC_BREAK: begin
          ref_v <= 1'b0;
          cnt   <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lb_ext_oneshot.sv
module lb_ext_oneshot #(
  parameter int EW     = 9,
  parameter int EXT_MS = 500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          v_pace,
  output logic          confirmed,
  output logic          ext_cmd,
  output logic [EW-1:0] ext_ms
);
  localparam logic [EW-1:0] EXT_VAL = EW'(EXT_MS);

  logic used;

  always_ff @(posedge clk) begin
    if (rst) begin
      confirmed <= 1'b0;
      used      <= 1'b0;
      ext_cmd   <= 1'b0;
      ext_ms    <= '0;
    end else begin
      if (hit) confirmed <= 1'b1;
      if (v_pace && confirmed && !used) begin
        ext_cmd <= 1'b1;
        ext_ms  <= EXT_VAL;
        used    <= 1'b1;
      end else begin
        ext_cmd <= 1'b0;
        ext_ms  <= '0;
      end
    end
  end
endmodule

// File: rtl/loop_breaker.sv
module loop_breaker
  import lb_pkg::*;
#(
  parameter int TOL_MS  = DEF_TOL_MS,
  parameter int MATCH_N = DEF_MATCH_N,
  parameter int MAX_MS  = DEF_MAX_MS,
  parameter int EXT_MS  = DEF_EXT_MS,
  localparam int TW = $clog2(MAX_MS + 1),
  localparam int CW = $clog2(MATCH_N + 1),
  localparam int EW = $clog2(EXT_MS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_ms,
  input  logic          v_pace,
  input  logic          v_sense,
  input  logic          a_pace,
  input  logic          a_sense,
  input  logic          at_upper,
  output logic          loop_confirmed,
  output logic          arp_ext_cmd,
  output logic [EW-1:0] arp_ext_ms
);
  logic          run_abort;
  logic          cap_v;
  logic [TW-1:0] cap_val;
  logic          hit;

  assign run_abort = v_sense | a_pace | ~at_upper;

  lb_span_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_ms),
    .start   (v_pace & ~loop_confirmed),
    .stop    (a_sense),
    .abort   (run_abort),
    .cap_v   (cap_v),
    .cap_val (cap_val)
  );

  lb_run_track #(
    .TW(TW), .CW(CW), .TOL_MS(TOL_MS), .MATCH_N(MATCH_N)
  ) u_track (
    .clk     (clk),
    .rst     (rst),
    .abort   (run_abort),
    .hold    (loop_confirmed),
    .cap_v   (cap_v),
    .cap_val (cap_val),
    .hit     (hit)
  );

  lb_ext_oneshot #(.EW(EW), .EXT_MS(EXT_MS)) u_ext (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .v_pace    (v_pace),
    .confirmed (loop_confirmed),
    .ext_cmd   (arp_ext_cmd),
    .ext_ms    (arp_ext_ms)
  );
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int EW     = 9,
  parameter int EXT_MS = 500
) (
  input logic          clk,
  input logic          rst,
  input logic          v_pace,
  input logic          loop_confirmed,
  input logic          arp_ext_cmd,
  input logic [EW-1:0] arp_ext_ms
);
  logic fired;

  always_ff @(posedge clk) begin
    if (rst)              fired <= 1'b0;
    else if (arp_ext_cmd) fired <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!loop_confirmed && !arp_ext_cmd && arp_ext_ms == '0));

  p_sticky_status_r5: assert property (@(posedge clk) disable iff (rst)
    loop_confirmed |=> loop_confirmed);

  p_cmd_follows_pace_r8: assert property (@(posedge clk) disable iff (rst)
    arp_ext_cmd |-> ($past(v_pace) && $past(loop_confirmed)));

  p_cmd_length_r8: assert property (@(posedge clk) disable iff (rst)
    arp_ext_cmd |-> (arp_ext_ms == EW'(EXT_MS)));

  p_len_only_with_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (arp_ext_ms != '0) |-> arp_ext_cmd);

  p_single_shot_r9: assert property (@(posedge clk) disable iff (rst)
    arp_ext_cmd |-> !fired);
endmodule

bind loop_breaker lb_checker #(.EW(EW), .EXT_MS(EXT_MS)) u_lb_chk (
  .clk            (clk),
  .rst            (rst),
  .v_pace         (v_pace),
  .loop_confirmed (loop_confirmed),
  .arp_ext_cmd    (arp_ext_cmd),
  .arp_ext_ms     (arp_ext_ms)
);

// File: tb/loop_breaker_test.sv
module loop_breaker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 0, v_pace = 0, v_sense = 0, a_pace = 0, a_sense = 0;
  logic at_upper = 1'b1;
  logic       loop_confirmed, arp_ext_cmd;
  logic [8:0] arp_ext_ms;

  int n_checks = 0;
  int n_errors = 0;
  int ext_seen = 0;
  bit done = 0;

  bit    q_conf[$];
  int    q_ext[$];
  string q_req[$];

  always #5 clk = ~clk;

  loop_breaker uut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .v_pace(v_pace),
    .v_sense(v_sense), .a_pace(a_pace), .a_sense(a_sense),
    .at_upper(at_upper), .loop_confirmed(loop_confirmed),
    .arp_ext_cmd(arp_ext_cmd), .arp_ext_ms(arp_ext_ms)
  );

  // Pulse monitor: counts extension commands and checks their length (R8)
  always @(negedge clk) begin
    if (rst) ext_seen = 0;
    else if (arp_ext_cmd) begin
      ext_seen++;
      n_checks++;
      if (arp_ext_ms != 9'd500) begin
        n_errors++;
        $display("FAIL R8 ext length: actual=%0d expected=500", arp_ext_ms);
      end
    end
  end

  // Scoreboard monitor: pops one expectation per cycle and compares
  always @(negedge clk) begin
    if (q_conf.size() > 0) begin
      bit e_c; int e_x; string r;
      e_c = q_conf.pop_front();
      e_x = q_ext.pop_front();
      r   = q_req.pop_front();
      n_checks++;
      if (loop_confirmed !== e_c || ext_seen != e_x) begin
        n_errors++;
        $display("FAIL %s: actual confirmed=%0b ext=%0d expected confirmed=%0b ext=%0d",
                 r, loop_confirmed, ext_seen, e_c, e_x);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input bit c, input int x, input string r);
    q_conf.push_back(c);
    q_ext.push_back(x);
    q_req.push_back(r);
    cyc(2);
  endtask

  task automatic do_reset();
    rst = 1'b1; at_upper = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic beat(input int d);
    v_pace = 1'b1; cyc(1); v_pace = 1'b0;
    tick_ms = 1'b1; cyc(d); tick_ms = 1'b0;
    a_sense = 1'b1; cyc(1); a_sense = 1'b0;
    cyc(4);
  endtask

  task automatic beats(input int n, input int d);
    for (int i = 0; i < n; i++) beat(d);
  endtask

  initial begin
    do_reset();
    // R1: reset state
    n_checks++;
    if (arp_ext_cmd !== 1'b0 || arp_ext_ms !== 9'd0) begin
      n_errors++;
      $display("FAIL R1: actual cmd=%0b ms=%0d expected 0 0", arp_ext_cmd, arp_ext_ms);
    end
    expect_state(0, 0, "R1 reset status");

    // R3/R4/R5: ref 200, matches at +32 and -32
    beat(200);
    for (int i = 0; i < 15; i++) beat((i % 2) ? 168 : 232);
    expect_state(0, 0, "R5 not after 15 matches");
    beat(232);
    expect_state(1, 0, "R4 R5 confirm on 16th match");

    // R8: next pace gives one command
    v_pace = 1'b1; cyc(1); v_pace = 1'b0; cyc(3);
    expect_state(1, 1, "R8 one extension on next pace");

    // R9: no second command
    v_pace = 1'b1; cyc(1); v_pace = 1'b0; cyc(3);
    beats(17, 200);
    expect_state(1, 1, "R9 once only");

    // R6: break at 33 ms discards reference
    do_reset();
    expect_state(0, 0, "R1 after reset");
    beat(300);
    beats(10, 332);
    beat(333);
    beats(16, 340);
    expect_state(0, 0, "R6 run restarts after break");
    beat(340);
    expect_state(1, 0, "R6 R3 new reference confirms");

    // R7: ventricular sense
    do_reset();
    beats(10, 120);
    v_sense = 1'b1; cyc(1); v_sense = 1'b0; cyc(2);
    beats(16, 120);
    expect_state(0, 0, "R7 v_sense ends run");
    beat(120);
    expect_state(1, 0, "R7 confirm after fresh run");

    // R7: atrial pace
    do_reset();
    beats(10, 120);
    a_pace = 1'b1; cyc(1); a_pace = 1'b0; cyc(2);
    beats(16, 120);
    expect_state(0, 0, "R7 a_pace ends run");

    // R7: rate leaves upper limit
    do_reset();
    beats(10, 120);
    at_upper = 1'b0; cyc(1); at_upper = 1'b1; cyc(2);
    beats(16, 120);
    expect_state(0, 0, "R7 at_upper low ends run");

    // R2: stray atrial sense ignored
    do_reset();
    beats(8, 150);
    a_sense = 1'b1; cyc(1); a_sense = 1'b0; cyc(4);
    beats(8, 150);
    expect_state(0, 0, "R2 stray sense no count");
    beat(150);
    expect_state(1, 0, "R2 stray sense no break");

    cyc(4);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule